// File: doc/BRIEF.md
# Modulation-Order Row-Column Bit Interleaver

This block reorders the bits of one coded block of E bits after rate matching, before symbol mapping. Conceptually the bits go into a matrix with Qm rows and E/Qm columns. Qm is the modulation order and is chosen at run time from 1, 2, 4 or 8. The matrix is filled one row at a time and emptied one column at a time. With this ordering, the Qm bits that go to one modulation symbol come from Qm points in the block that lie E/Qm bits apart.

Each block has two phases. First comes a configuration pulse that carries E and the Qm code. Then the data flows. The input stream is 32 bits wide with valid/ready and takes one word per clock. The whole block is buffered internally. Only after the final input word has been taken does the output stream start, also 32 bits wide with valid/ready. A bit count marks how many bits of the final output word are meaningful.

For each output word, one 32-bit window is gathered per matrix row, and the row segments are spread into the word at a stride of Qm. When Qm is 1 the gather engine reads whole aligned words and forwards them without any shifting.

Top module: `bi_qm_interleaver`

## Requirements
- R1: After reset, `out_valid_o`, `in_ready_o` and `cfg_err_o` are all low.
- R2: A `cfg_start_i` pulse in the idle state is accepted only if E is nonzero, E is at most MAX_E (25344 by default), and E is a multiple of the row count. The row count is taken from `cfg_qm_i`: code 0 gives 1 row, 1 gives 2, 2 gives 4 and 3 gives 8. If the pulse is rejected, `cfg_err_o` goes high from the next cycle and the block stays idle with `in_ready_o` low. An accepted pulse clears `cfg_err_o`.
- R3: From the cycle after an accepted configuration, `in_ready_o` stays high until ceil(E/32) words have been taken, and then it falls. `out_valid_o` stays low while input is being taken.
- R4: Bit b of input word n is stream bit 32n+b. Bits of the final input word at positions E and above have no effect on any output bit.
- R5: Output stream bit j*Qm+i equals input stream bit i*(E/Qm)+j, for row i < Qm and column j < E/Qm. Output bit b of word n is stream bit 32n+b.
- R6: With row count 1, the output stream is identical to the input stream.
- R7: Exactly ceil(E/32) output words are produced. `out_nbits_o` is 32 on every word except the final one, where it is E-32*(ceil(E/32)-1). `out_last_o` is high only on the final word. Bits at positions at or above `out_nbits_o` are zero.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o`, `out_nbits_o` and `out_last_o` hold their values.
- R9: A `cfg_start_i` pulse that arrives while a block is being taken in or given out has no effect on that block or on `cfg_err_o`.
- R10: Once the final output word has been taken, the block returns to idle, with both `in_ready_o` and `out_valid_o` low, and it accepts a new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_start_i | input | 1 | Configuration pulse, sampled in idle |
| cfg_len_i | input | 15 | Block length E in bits |
| cfg_qm_i | input | 2 | Row-count code: 0/1/2/3 selects 1/2/4/8 rows |
| cfg_err_o | output | 1 | Last configuration pulse was rejected |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word, bit 0 first in stream order |
| in_ready_o | output | 1 | Block is taking input words |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word, bit 0 first in stream order |
| out_nbits_o | output | 6 | Number of meaningful bits in the output word (1 to 32) |
| out_last_o | output | 1 | Final output word of the block |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
The properties assume that the environment pulses `cfg_start_i` for a single cycle, and that `cfg_len_i` and `cfg_qm_i` are steady during that cycle. They make no assumption about the timing of `out_ready_i`, so a stalled word has to hold its value whatever the downstream does. The stimulus respects these assumptions by driving every input only on the falling clock edge. Configuration pulses are exactly one cycle wide. Input gaps and output back-pressure are drawn at random, but they never change a word that is still waiting to be taken.

// File: rtl/bi_pkg.sv
package bi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } bi_state_e;

  // Row count for a 2-bit modulation code.
  function automatic logic [3:0] rows_of(input logic [1:0] qcode);
    return 4'(1) << qcode;
  endfunction

endpackage

// File: rtl/bi_cfg.sv
module bi_cfg #(
  parameter int unsigned MAX_E = 25344,
  parameter int unsigned DW    = 32,
  parameter int unsigned LW    = $clog2(MAX_E + 1),
  parameter int unsigned WAW   = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           idle_i,
  input  logic [LW-1:0]  len_i,
  input  logic [1:0]     qcode_i,
  output logic           accept_o,
  output logic           err_o,
  output logic [LW-1:0]  len_o,
  output logic [1:0]     qcode_o,
  output logic [LW-1:0]  cols_o,
  output logic [WAW-1:0] last_wr_o
);

  localparam int unsigned DWL = $clog2(DW);

  logic [LW-1:0] qmask;
  logic          len_ok;

  always_comb begin
    qmask  = (LW'(1) << qcode_i) - LW'(1);
    len_ok = (len_i != '0) && (len_i <= LW'(MAX_E)) && ((len_i & qmask) == '0);
  end

  assign accept_o = start_i && idle_i && len_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o     <= 1'b0;
      len_o     <= '0;
      qcode_o   <= '0;
      cols_o    <= '0;
      last_wr_o <= '0;
    end else if (accept_o) begin
      err_o     <= 1'b0;
      len_o     <= len_i;
      qcode_o   <= qcode_i;
      cols_o    <= len_i >> qcode_i;
      last_wr_o <= WAW'((len_i - LW'(1)) >> DWL);
    end else if (start_i && idle_i) begin
      err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/bi_bank.sv
module bi_bank #(
  parameter int unsigned DEPTH = 396,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/bi_gather.sv
module bi_gather #(
  parameter int unsigned DW  = 32,
  parameter int unsigned DWL = $clog2(DW)
) (
  input  logic [DW-1:0]  lo_i,
  input  logic [DW-1:0]  hi_i,
  input  logic [DWL-1:0] off_i,
  input  logic [1:0]     qcode_i,
  input  logic [2:0]     row_i,
  input  logic [DW-1:0]  acc_i,
  output logic [DW-1:0]  acc_o
);

  logic [2*DW-1:0] win;
  logic [DW-1:0]   seg;
  logic [DWL-1:0]  pos;

  always_comb begin
    win = {hi_i, lo_i} >> off_i;
    // single row: windows are word aligned, skip the funnel
    seg = (qcode_i == 2'd0) ? lo_i : win[DW-1:0];
    acc_o = acc_i;
    pos   = '0;
    for (int m = 0; m < DW; m++) begin
      if (m < int'(DW >> qcode_i)) begin
        pos        = DWL'((m << qcode_i) | int'(row_i));
        acc_o[pos] = seg[m];
      end
    end
  end

endmodule

// File: rtl/bi_qm_interleaver.sv
module bi_qm_interleaver
  import bi_pkg::*;
#(
  parameter int unsigned MAX_E = 25344,
  parameter int unsigned DW    = 32,
  localparam int unsigned LW   = $clog2(MAX_E + 1),
  localparam int unsigned NBW  = $clog2(DW) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_start_i,
  input  logic [LW-1:0]  cfg_len_i,
  input  logic [1:0]     cfg_qm_i,
  output logic           cfg_err_o,
  input  logic           in_valid_i,
  input  logic [DW-1:0]  in_data_i,
  output logic           in_ready_o,
  output logic           out_valid_o,
  output logic [DW-1:0]  out_data_o,
  output logic [NBW-1:0] out_nbits_o,
  output logic           out_last_o,
  input  logic           out_ready_i
);

  localparam int unsigned DWL    = $clog2(DW);
  localparam int unsigned NWORD  = (MAX_E + DW - 1) / DW;
  localparam int unsigned BANK_D = (NWORD + 1) / 2;
  localparam int unsigned BAW    = $clog2(BANK_D);
  localparam int unsigned WAW    = $clog2(NWORD);
  localparam int unsigned PW     = LW + 1;
  localparam int unsigned RWW    = PW - DWL;

  bi_state_e state_q;

  logic           cfg_acc;
  logic [LW-1:0]  len;
  logic [1:0]     qcode;
  logic [LW-1:0]  cols;
  logic [WAW-1:0] last_wr;

  bi_cfg #(.MAX_E(MAX_E), .DW(DW), .LW(LW), .WAW(WAW)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cfg_start_i),
    .idle_i    (state_q == ST_IDLE),
    .len_i     (cfg_len_i),
    .qcode_i   (cfg_qm_i),
    .accept_o  (cfg_acc),
    .err_o     (cfg_err_o),
    .len_o     (len),
    .qcode_o   (qcode),
    .cols_o    (cols),
    .last_wr_o (last_wr)
  );

  // write side
  logic [WAW-1:0] wr_ptr_q;
  logic           wr_fire;

  assign in_ready_o = (state_q == ST_FILL);
  assign wr_fire    = in_valid_i && in_ready_o;

  // drain side
  logic [PW-1:0]  rptr_q, base_q, seg_len;
  logic [3:0]     iss_cnt_q, rows;
  logic           issue;
  logic [RWW-1:0] rd_word;
  logic [RWW-1:0] hi_word;
  logic [BAW-1:0] rd_addr [2];

  logic           cap_vld_q, cap_swap_q, cap_last;
  logic [2:0]     cap_row_q;
  logic [DWL-1:0] cap_off_q;
  logic [DW-1:0]  acc_q, acc_nxt;
  logic [DW-1:0]  rd_data [2];
  logic [DW-1:0]  lo_w, hi_w;

  logic           ov_q, out_fire;
  logic [DW-1:0]  od_q, nb_mask;
  logic [LW-1:0]  rem_q;

  assign rows    = rows_of(qcode);
  assign seg_len = PW'(DW) >> qcode;
  assign issue   = (state_q == ST_DRAIN) && !ov_q && (iss_cnt_q < rows);
  assign rd_word = rptr_q[PW-1:DWL];
  assign hi_word = (rd_word >> 1) + RWW'(1);

  always_comb begin
    rd_addr[1] = BAW'(rd_word >> 1);
    if (!rd_word[0])                     rd_addr[0] = BAW'(rd_word >> 1);
    else if (hi_word >= RWW'(BANK_D))    rd_addr[0] = '0;
    else                                 rd_addr[0] = BAW'(hi_word);
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    bi_bank #(.DEPTH(BANK_D), .DW(DW), .AW(BAW)) i_bank (
      .clk_i   (clk_i),
      .we_i    (wr_fire && (wr_ptr_q[0] == 1'(b))),
      .waddr_i (BAW'(wr_ptr_q >> 1)),
      .wdata_i (in_data_i),
      .re_i    (issue),
      .raddr_i (rd_addr[b]),
      .rdata_o (rd_data[b])
    );
  end

  assign lo_w = cap_swap_q ? rd_data[1] : rd_data[0];
  assign hi_w = cap_swap_q ? rd_data[0] : rd_data[1];

  bi_gather #(.DW(DW), .DWL(DWL)) i_gather (
    .lo_i    (lo_w),
    .hi_i    (hi_w),
    .off_i   (cap_off_q),
    .qcode_i (qcode),
    .row_i   (cap_row_q),
    .acc_i   (acc_q),
    .acc_o   (acc_nxt)
  );

  assign cap_last    = cap_vld_q && (cap_row_q == 3'(rows - 4'd1));
  assign out_nbits_o = (rem_q >= LW'(DW)) ? NBW'(DW) : NBW'(rem_q);
  assign out_last_o  = (rem_q <= LW'(DW));
  assign nb_mask     = ~({DW{1'b1}} << out_nbits_o);
  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;
  assign out_fire    = ov_q && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wr_ptr_q   <= '0;
      rptr_q     <= '0;
      base_q     <= '0;
      iss_cnt_q  <= '0;
      cap_vld_q  <= 1'b0;
      cap_swap_q <= 1'b0;
      cap_row_q  <= '0;
      cap_off_q  <= '0;
      acc_q      <= '0;
      ov_q       <= 1'b0;
      od_q       <= '0;
      rem_q      <= '0;
    end else begin
      cap_vld_q <= issue;
      if (issue) begin
        cap_row_q  <= iss_cnt_q[2:0];
        cap_off_q  <= rptr_q[DWL-1:0];
        cap_swap_q <= rd_word[0];
        rptr_q     <= rptr_q + PW'(cols);
        iss_cnt_q  <= iss_cnt_q + 4'd1;
      end
      if (cap_vld_q) begin
        acc_q <= acc_nxt;
        if (cap_last) begin
          ov_q <= 1'b1;
          od_q <= acc_nxt & nb_mask;
        end
      end
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_acc) begin
            state_q  <= ST_FILL;
            wr_ptr_q <= '0;
          end
        end
        ST_FILL: begin
          if (wr_fire) begin
            wr_ptr_q <= wr_ptr_q + WAW'(1);
            if (wr_ptr_q == last_wr) begin
              state_q   <= ST_DRAIN;
              rptr_q    <= '0;
              base_q    <= '0;
              iss_cnt_q <= '0;
              acc_q     <= '0;
              rem_q     <= len;
            end
          end
        end
        ST_DRAIN: begin
          if (out_fire) begin
            ov_q      <= 1'b0;
            acc_q     <= '0;
            iss_cnt_q <= '0;
            base_q    <= base_q + seg_len;
            rptr_q    <= base_q + seg_len;
            rem_q     <= rem_q - LW'(DW);
            if (out_last_o) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bi_qm_interleaver_chk.sv
module bi_qm_interleaver_chk #(
  parameter int unsigned DW  = 32,
  parameter int unsigned NBW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_start_i,
  input logic           cfg_err_o,
  input logic           in_ready_o,
  input logic           out_valid_o,
  input logic [DW-1:0]  out_data_o,
  input logic [NBW-1:0] out_nbits_o,
  input logic           out_last_o,
  input logic           out_ready_i
);

  p_err_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !in_ready_o);

  p_ready_needs_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> $past(cfg_start_i));

  p_fill_drain_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  p_nbits_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_nbits_o != '0) && (out_nbits_o <= NBW'(DW)));

  p_full_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> (out_nbits_o == NBW'(DW)));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o)
      && $stable(out_nbits_o) && $stable(out_last_o));

endmodule

bind bi_qm_interleaver bi_qm_interleaver_chk #(.DW(DW), .NBW(NBW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_start_i (cfg_start_i),
  .cfg_err_o   (cfg_err_o),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_nbits_o (out_nbits_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/test_bi_qm_interleaver.sv
module test_bi_qm_interleaver;

  localparam int MAX_E = 25344;
  localparam int DW    = 32;
  localparam int LW    = 15;
  localparam int NBW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           cfg_start = 1'b0;
  logic [LW-1:0]  cfg_len = '0;
  logic [1:0]     cfg_qm = '0;
  logic           cfg_err;
  logic           in_valid = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic           in_ready;
  logic           out_valid;
  logic [DW-1:0]  out_data;
  logic [NBW-1:0] out_nbits;
  logic           out_last;
  logic           out_ready = 1'b0;

  bi_qm_interleaver i_bi_qm_interleaver (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_start_i (cfg_start),
    .cfg_len_i   (cfg_len),
    .cfg_qm_i    (cfg_qm),
    .cfg_err_o   (cfg_err),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_nbits_o (out_nbits),
    .out_last_o  (out_last),
    .out_ready_i (out_ready)
  );

  // scoreboard entry: {last, nbits, data}
  logic [DW+NBW:0] exp_q[$];
  int checks = 0;
  int errors = 0;
  int rdy_pct = 70;
  int cur_qc = 0;
  bit filling = 1'b0;
  bit saw_early = 1'b0;
  bit stall_prev = 1'b0;
  logic [DW-1:0] stall_data = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_cfg(input int e, input int qc);
    @(negedge clk);
    cfg_start = 1'b1;
    cfg_len   = LW'(e);
    cfg_qm    = 2'(qc);
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic run_block(input int e, input int qc, input bit busy_start);
    int q, c, nw;
    logic [DW-1:0] wq[];
    q  = 1 << qc;
    c  = e / q;
    nw = (e + DW - 1) / DW;
    wq = new[nw];
    cur_qc = qc;
    for (int w = 0; w < nw; w++) wq[w] = $urandom;
    for (int o = 0; o < nw; o++) begin
      logic [DW-1:0] d;
      int nb;
      d  = '0;
      nb = (e - o * DW > DW) ? DW : e - o * DW;
      for (int b = 0; b < nb; b++) begin
        int k, src;
        k   = o * DW + b;
        src = (k % q) * c + (k / q);
        d[b] = wq[src / DW][src % DW];
      end
      exp_q.push_back({(o == nw - 1), NBW'(nb), d});
    end

    send_cfg(e, qc);
    check(cfg_err == 1'b0, "R2", "err after valid cfg", cfg_err, 0);
    check(in_ready == 1'b1, "R3", "ready after cfg", in_ready, 1);
    filling   = 1'b1;
    saw_early = 1'b0;
    for (int w = 0; w < nw; w++) begin
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = wq[w];
      if (busy_start && w == 1) begin
        cfg_start = 1'b1;
        cfg_len   = LW'(64);
        cfg_qm    = 2'(3 - qc);
      end
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      cfg_start = 1'b0;
    end
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R3", "ready after last word", in_ready, 0);
    filling = 1'b0;
    check(saw_early == 1'b0, "R3", "output during fill", saw_early, 0);
    if (busy_start) check(cfg_err == 1'b0, "R9", "err after busy start", cfg_err, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!out_valid && !in_ready, "R10", "idle after block",
          {out_valid, in_ready}, 0);
  endtask

  // monitor: back-pressure, stall hold and scoreboard compare
  always @(negedge clk) begin
    bit rn;
    if (rst_n) begin
      rn = ($urandom % 100) < rdy_pct;
      if (filling && out_valid) saw_early = 1'b1;
      if (stall_prev) begin
        check(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
        check(out_data == stall_data, "R8", "data held", out_data, stall_data);
      end
      out_ready  = rn;
      stall_prev = out_valid && !rn;
      stall_data = out_data;
      if (out_valid && rn) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected word", out_data, 0);
        end else begin
          logic [DW+NBW:0] ex;
          string req;
          ex  = exp_q.pop_front();
          req = (ex[DW+NBW-1:DW] != NBW'(DW)) ? "R4" : ((cur_qc == 0) ? "R6" : "R5");
          check(out_data == ex[DW-1:0], req, "data", out_data, ex[DW-1:0]);
          check(out_nbits == ex[DW+NBW-1:DW], "R7", "nbits", out_nbits, ex[DW+NBW-1:DW]);
          check(out_last == ex[DW+NBW], "R7", "last", out_last, ex[DW+NBW]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
    check(in_ready == 1'b0, "R1", "in_ready at reset", in_ready, 0);
    check(cfg_err == 1'b0, "R1", "cfg_err at reset", cfg_err, 0);

    send_cfg(50, 2);
    check(cfg_err == 1'b1, "R2", "E not multiple of 4", cfg_err, 1);
    check(in_ready == 1'b0, "R2", "idle after reject", in_ready, 0);
    send_cfg(0, 0);
    check(cfg_err == 1'b1, "R2", "E zero", cfg_err, 1);
    send_cfg(MAX_E + 1, 0);
    check(cfg_err == 1'b1, "R2", "E above max", cfg_err, 1);
    send_cfg(13, 1);
    check(cfg_err == 1'b1 && in_ready == 1'b0, "R2", "odd E with 2 rows",
          {cfg_err, in_ready}, 2);

    rdy_pct = 100;
    run_block(64, 0, 1'b0);
    run_block(33, 0, 1'b0);
    rdy_pct = 60;
    run_block(100, 1, 1'b0);
    run_block(96, 2, 1'b1);
    run_block(1000, 3, 1'b0);
    rdy_pct = 40;
    run_block(24, 3, 1'b0);
    run_block(4004, 2, 1'b1);
    rdy_pct = 80;
    run_block(MAX_E, 3, 1'b0);
    run_block(MAX_E, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule